// File: doc/BRIEF.md
# Serial EEPROM Slave with Write Protection

This block is a 128-word by 16-bit serial EEPROM slave behind a four-wire serial port. The four wires are chip select, serial clock, data in, and a data out that has its own output-enable. A host raises chip select and shifts in a start bit, a two-bit opcode and a seven-bit address. It may then shift in or read out 16-bit words. All serial inputs are synchronised into the system clock. Edges of the serial clock are detected there, so the serial clock must run much slower than the system clock.

Writes are guarded in two ways. The first is a write-enable latch that the host sets and clears with dedicated commands. The second is a level input that, when low, locks the lower half of the array. An accepted write starts a self-timed programming period. That period is a parameterised count of system clocks. During it, data out reports busy, then ready. A read streams words from the addressed location onward and wraps at the top of the array. The storage is a plain register file.

Top module: `eep_slave`

## Requirements
- R1: After reset every word of the array reads as zero, the write-enable latch is clear, and data out is not driven.
- R2: Data in is sampled on rising serial clock edges. While chip select is high and no instruction is in progress, 0 bits are ignored. The first 1 is the start bit. It is followed by a 2-bit opcode and a 7-bit address, each sent most significant bit first.
- R3: A READ uses opcode 10. Once the last address bit is in, data out drives a single 0 dummy bit. It then drives the 16 bits of the addressed word, most significant first, with one new bit after each rising serial clock edge.
- R4: If the serial clock keeps running after a word has been read, the next address follows with no extra dummy bit. Address 0x7F is followed by 0x00.
- R5: A WRITE uses opcode 01 and is carried out only while the write-enable latch is set. Opcode 00 with address bits [6:5] = 11 sets the latch. Opcode 00 with address bits [6:5] = 00 clears it. READ works whatever the latch holds.
- R6: Opcode 00 with address bits [6:5] = 01 is a write-all request. It may be followed by data bits, and it changes neither the array nor the latch.
- R7: An accepted WRITE starts on the edge that captures the last data bit. Data out then reads 0 whenever chip select is high, for PROG_CYCLES system clocks. After that the word is stored and data out reads 1. The 1 stays through chip select toggles and 0 bits, and is released by the next start bit.
- R8: The data out enable is low whenever chip select is low. It is also low whenever neither read data nor status is being driven.
- R9: While fullWriteEn is low, writes to addresses 0x00 to 0x3F are not performed, and writes to 0x40 to 0x7F still are.
- R10: A WRITE blocked by the latch or by protection causes no busy period. Data out reads 1 immediately after the last data bit.
- R11: If chip select falls before an instruction is complete, the instruction is abandoned and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chipSel | input | 1 | Chip select, active high |
| serClk | input | 1 | Serial clock from the host |
| serIn | input | 1 | Serial data in |
| fullWriteEn | input | 1 | High makes all addresses writable; low locks 0x00 to 0x3F |
| serOut | output | 1 | Serial data out (read bits or busy/ready) |
| serOutEn | output | 1 | Output enable for serOut; low means high impedance |

## Verification
The bench first walks a table of mixed writes and read-backs, then targets the edges of the protocol. A design that emitted no dummy bit, or one that put a dummy bit between words, would shift every word read by one position. A design that forgot to wrap would read a garbage word after 0x7F. The bench sends leading zeros before a start bit and zero bits while ready is shown; a design that treated either as a start would decode the wrong opcode or drop the ready indication early. Finally, it blocks writes through the latch, through protection and through a mid-word deselect, and probes the write-all request. A design that leaks any of these into the array, or that raises busy for a blocked write, fails a read-back or a status check.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_PROG,
    ST_READY,
    ST_WAITCS
  } ctlState_t;

  typedef enum logic [1:0] {
    OUT_HIZ,
    OUT_BIT,
    OUT_BUSY,
    OUT_READY
  } outMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic latchAddr;
    logic latchData;
    logic outZero;
    logic outLoad;
    logic incAddr;
    logic commit;
  } dpCtl_t;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_MISC  = 2'b00;
  localparam logic [1:0] SUB_EN   = 2'b11;
  localparam logic [1:0] SUB_DIS  = 2'b00;

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] level
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] stage;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= '0;
        else        stage <= rawIn;
      end
      assign level = stage;
    end else begin : g_chain
      logic [WIDTH-1:0] chain [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
          chain[0] <= rawIn;
          for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
      end
      assign level = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/eep_dpath.sv
module eep_dpath
  import eep_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  dpCtl_t            ctl,
  input  logic [BIT_W-1:0]  bitSel,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              addrLow,
  output logic              outBit
);

  logic [DATA_W-1:0] inShift;
  logic [DATA_W-1:0] wrWord;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] mem [DEPTH];

  assign cmdAddr = {inShift[ADDR_W-2:0], din};
  assign addrLow = ~addrReg[ADDR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inShift <= '0;
      wrWord  <= '0;
      addrReg <= '0;
      outBit  <= 1'b0;
    end else begin
      if (ctl.shiftIn)   inShift <= {inShift[DATA_W-2:0], din};
      if (ctl.latchData) wrWord  <= {inShift[DATA_W-2:0], din};
      if (ctl.latchAddr) addrReg <= cmdAddr;
      else if (ctl.incAddr) addrReg <= addrReg + 1'b1;
      if (ctl.outZero)     outBit <= 1'b0;
      else if (ctl.outLoad) outBit <= mem[addrReg][bitSel];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (ctl.commit) begin
      mem[addrReg] <= wrWord;
    end
  end

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.incAddr |=> addrReg == ADDR_W'($past(addrReg) + 1));

  // R7
  commit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.commit |=> mem[$past(addrReg)] == $past(wrWord));

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 1000,
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int CNT_W  = $clog2(DATA_W + ADDR_W + 1),
  localparam int PCNT_W = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csHigh,
  input  logic              skLevel,
  input  logic              din,
  input  logic              fullWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              addrLow,
  output dpCtl_t            ctl,
  output logic [BIT_W-1:0]  bitSel,
  output outMode_t          mode
);

  ctlState_t         state;
  logic [1:0]        opReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [PCNT_W-1:0] progCnt;
  logic              weLatch;
  logic              skPrev;

  logic       skRise, edgeOn, lastAddrBit, lastDataBit, writeOk;
  logic [1:0] subCode;

  assign skRise      = skLevel & ~skPrev;
  assign edgeOn      = skRise & csHigh;
  assign lastAddrBit = (state == ST_ADDR)  && edgeOn && (bitCnt == CNT_W'(1));
  assign lastDataBit = (state == ST_WDATA) && edgeOn && (bitCnt == CNT_W'(1));
  assign subCode     = cmdAddr[ADDR_W-1 -: 2];
  assign writeOk     = weLatch && (fullWrite || !addrLow);
  assign bitSel      = bitCnt[BIT_W-1:0];

  always_comb begin
    ctl           = '0;
    ctl.shiftIn   = edgeOn && (state == ST_ADDR || state == ST_WDATA);
    ctl.latchAddr = lastAddrBit && (opReg == OP_READ || opReg == OP_WRITE);
    ctl.outZero   = lastAddrBit && (opReg == OP_READ);
    ctl.latchData = lastDataBit;
    ctl.outLoad   = (state == ST_RDATA) && edgeOn;
    ctl.incAddr   = ctl.outLoad && (bitCnt == '0);
    ctl.commit    = (state == ST_PROG) && (progCnt == PCNT_W'(1));
  end

  always_comb begin
    case (state)
      ST_RDATA: mode = OUT_BIT;
      ST_PROG:  mode = OUT_BUSY;
      ST_READY: mode = OUT_READY;
      default:  mode = OUT_HIZ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      opReg   <= '0;
      bitCnt  <= '0;
      progCnt <= '0;
      weLatch <= 1'b0;
      skPrev  <= 1'b0;
    end else begin
      skPrev <= skLevel;
      case (state)
        ST_IDLE, ST_READY: begin
          if (edgeOn && din) begin
            state  <= ST_OPC;
            bitCnt <= CNT_W'(2);
          end
        end
        ST_OPC: begin
          if (!csHigh) state <= ST_IDLE;
          else if (skRise) begin
            opReg <= {opReg[0], din};
            if (bitCnt == CNT_W'(1)) begin
              state  <= ST_ADDR;
              bitCnt <= CNT_W'(ADDR_W);
            end else bitCnt <= bitCnt - 1'b1;
          end
        end
        ST_ADDR: begin
          if (!csHigh) state <= ST_IDLE;
          else if (skRise) begin
            if (bitCnt == CNT_W'(1)) begin
              case (opReg)
                OP_READ: begin
                  state  <= ST_RDATA;
                  bitCnt <= CNT_W'(DATA_W - 1);
                end
                OP_WRITE: begin
                  state  <= ST_WDATA;
                  bitCnt <= CNT_W'(DATA_W);
                end
                OP_MISC: begin
                  if (subCode == SUB_EN)       weLatch <= 1'b1;
                  else if (subCode == SUB_DIS) weLatch <= 1'b0;
                  state <= ST_WAITCS;
                end
                default: state <= ST_WAITCS;
              endcase
            end else bitCnt <= bitCnt - 1'b1;
          end
        end
        ST_WDATA: begin
          if (!csHigh) state <= ST_IDLE;
          else if (skRise) begin
            if (bitCnt == CNT_W'(1)) begin
              if (writeOk) begin
                state   <= ST_PROG;
                progCnt <= PCNT_W'(PROG_CYCLES);
              end else state <= ST_READY;
            end else bitCnt <= bitCnt - 1'b1;
          end
        end
        ST_RDATA: begin
          if (!csHigh) state <= ST_IDLE;
          else if (skRise)
            bitCnt <= (bitCnt == '0) ? CNT_W'(DATA_W - 1) : bitCnt - 1'b1;
        end
        ST_PROG: begin
          if (progCnt == PCNT_W'(1)) state <= ST_READY;
          else progCnt <= progCnt - 1'b1;
        end
        ST_WAITCS: begin
          if (!csHigh) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  lead_zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && edgeOn && !din) |=> state == ST_IDLE);

  // R11
  abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!csHigh && (state == ST_OPC || state == ST_ADDR || state == ST_WDATA))
      |=> state == ST_IDLE);

  // R5
  commit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.commit |-> weLatch);

  // R7
  prog_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG) |=> (state == ST_PROG || state == ST_READY));

endmodule

// File: rtl/eep_slave.sv
module eep_slave
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 1000,
  parameter int SYNC_STAGES = 2,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chipSel,
  input  logic serClk,
  input  logic serIn,
  input  logic fullWriteEn,
  output logic serOut,
  output logic serOutEn
);

  logic [3:0]        syncLvl;
  dpCtl_t            ctl;
  logic [BIT_W-1:0]  bitSel;
  logic [ADDR_W-1:0] cmdAddr;
  logic              addrLow, outBit;
  outMode_t          mode;

  eep_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rawIn ({fullWriteEn, serIn, serClk, chipSel}),
    .level (syncLvl)
  );

  eep_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .csHigh    (syncLvl[0]),
    .skLevel   (syncLvl[1]),
    .din       (syncLvl[2]),
    .fullWrite (syncLvl[3]),
    .cmdAddr   (cmdAddr),
    .addrLow   (addrLow),
    .ctl       (ctl),
    .bitSel    (bitSel),
    .mode      (mode)
  );

  eep_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (syncLvl[2]),
    .ctl     (ctl),
    .bitSel  (bitSel),
    .cmdAddr (cmdAddr),
    .addrLow (addrLow),
    .outBit  (outBit)
  );

  assign serOutEn = chipSel && (mode != OUT_HIZ);
  assign serOut   = serOutEn && ((mode == OUT_BIT) ? outBit : (mode == OUT_READY));

endmodule

// File: tb/eep_slave_test.sv
module eep_slave_test;

  localparam int CLK_PERIOD = 10;
  localparam int SKH        = 6;
  localparam int PROG       = 40;
  localparam int NVEC       = 12;

  // {isWrite, addr[6:0], data[15:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 7'h00, 16'h1234}, {1'b1, 7'h7F, 16'hA5C3}, {1'b1, 7'h40, 16'hFFFF},
    {1'b0, 7'h00, 16'h0000}, {1'b1, 7'h01, 16'h0001}, {1'b0, 7'h7F, 16'h0000},
    {1'b0, 7'h40, 16'h0000}, {1'b1, 7'h00, 16'h8000}, {1'b0, 7'h00, 16'h0000},
    {1'b0, 7'h01, 16'h0000}, {1'b1, 7'h3F, 16'h5A5A}, {1'b0, 7'h3F, 16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic chipSel = 1'b0, serClk = 1'b0, serIn = 1'b0, fullWriteEn = 1'b1;
  logic serOut, serOutEn;

  int   nChecks = 0, nFail = 0;
  logic done = 1'b0;
  logic [15:0] model [128];
  logic weModel = 1'b0;

  eep_slave #(.PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .chipSel(chipSel), .serClk(serClk),
    .serIn(serIn), .fullWriteEn(fullWriteEn), .serOut(serOut), .serOutEn(serOutEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic skPulse(input logic b);
    @(negedge clk) serIn = b;
    repeat (SKH) @(negedge clk);
    serClk = 1'b1;
    repeat (SKH) @(negedge clk);
    serClk = 1'b0;
  endtask

  task automatic sendBits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) skPulse(v[i]);
  endtask

  task automatic csUp();
    @(negedge clk) chipSel = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic startCmd(input logic [1:0] op, input logic [6:0] addr);
    csUp();
    skPulse(1'b1);
    sendBits({14'd0, op}, 2);
    sendBits({9'd0, addr}, 7);
  endtask

  task automatic endCs();
    @(negedge clk) chipSel = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic readNext(output logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      skPulse(1'b0);
      w[i] = serOut;
    end
  endtask

  task automatic readCheck(input logic [6:0] addr, input string req);
    logic [15:0] w;
    startCmd(2'b10, addr);
    check({req, " dummy bit R3"}, {30'd0, serOutEn, serOut}, 32'h2);
    readNext(w);
    check({req, " read data"}, {16'd0, w}, {16'd0, model[addr]});
    endCs();
  endtask

  task automatic doWrite(input logic [6:0] addr, input logic [15:0] data, input string req);
    logic ok;
    ok = weModel && (fullWriteEn || addr[6]);
    startCmd(2'b01, addr);
    sendBits(data, 16);
    if (ok) begin
      check({req, " busy R7"}, {30'd0, serOutEn, serOut}, 32'h2);
      repeat (PROG + 10) @(negedge clk);
      check({req, " ready R7"}, {30'd0, serOutEn, serOut}, 32'h3);
      model[addr] = data;
    end else begin
      check({req, " blocked ready R10"}, {30'd0, serOutEn, serOut}, 32'h3);
    end
    endCs();
  endtask

  task automatic setLatch(input logic en);
    startCmd(2'b00, en ? 7'b1100000 : 7'b0000000);
    endCs();
    weModel = en;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic        isW;
    logic [6:0]  va;
    logic [15:0] vd;
    for (int i = 0; i < 128; i++) model[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state: not driven, also not with chip select raised
    check("R1 oe after reset", {31'd0, serOutEn}, 32'd0);
    csUp();
    check("R1 R8 idle oe", {31'd0, serOutEn}, 32'd0);
    endCs();

    // R1 R5 write before enable is discarded
    doWrite(7'h45, 16'hBEEF, "R5 write w/o enable");
    readCheck(7'h45, "R1 R5 zero after reset");

    setLatch(1'b1);

    for (int i = 0; i < NVEC; i++) begin
      isW = VEC[i][23];
      va  = VEC[i][22:16];
      vd  = VEC[i][15:0];
      if (isW) doWrite(va, vd, "R7 table write");
      else     readCheck(va, "R3 table read");
    end

    // R4 sequential read with wrap
    startCmd(2'b10, 7'h7F);
    check("R3 dummy seq", {30'd0, serOutEn, serOut}, 32'h2);
    readNext(w);
    check("R4 word 7F", {16'd0, w}, {16'd0, model[7'h7F]});
    readNext(w);
    check("R4 wrap to 00", {16'd0, w}, {16'd0, model[7'h00]});
    readNext(w);
    check("R4 word 01", {16'd0, w}, {16'd0, model[7'h01]});
    endCs();
    check("R8 oe after deselect", {31'd0, serOutEn}, 32'd0);

    // R7 status persistence
    startCmd(2'b01, 7'h20);
    sendBits(16'h0F0F, 16);
    check("R7 busy", {30'd0, serOutEn, serOut}, 32'h2);
    repeat (PROG + 10) @(negedge clk);
    model[7'h20] = 16'h0F0F;
    @(negedge clk) chipSel = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 status hidden when deselected", {31'd0, serOutEn}, 32'd0);
    csUp();
    check("R7 ready after reselect", {30'd0, serOutEn, serOut}, 32'h3);
    skPulse(1'b0);
    check("R7 R2 ready kept through zero bit", {30'd0, serOutEn, serOut}, 32'h3);
    skPulse(1'b1);
    check("R7 start bit releases", {31'd0, serOutEn}, 32'd0);
    endCs();

    // R2 leading zeros then read
    csUp();
    skPulse(1'b0);
    skPulse(1'b0);
    skPulse(1'b1);
    sendBits(16'h0002, 2);
    sendBits(16'h0020, 7);
    check("R2 dummy after leading zeros", {30'd0, serOutEn, serOut}, 32'h2);
    readNext(w);
    check("R2 data after leading zeros", {16'd0, w}, 32'h0F0F);
    endCs();

    // R11 abort mid data
    startCmd(2'b01, 7'h20);
    sendBits(16'h03FF, 10);
    endCs();
    check("R11 no status after abort", {31'd0, serOutEn}, 32'd0);
    readCheck(7'h20, "R11 unchanged");

    // R6 write-all request ignored
    startCmd(2'b00, 7'b0100000);
    sendBits(16'h0000, 16);
    endCs();
    readCheck(7'h00, "R6 array kept");
    doWrite(7'h02, 16'hC0DE, "R6 latch kept");
    readCheck(7'h02, "R6 write works");

    // R9 protection
    fullWriteEn = 1'b0;
    repeat (6) @(negedge clk);
    doWrite(7'h10, 16'h7777, "R9 low half blocked");
    readCheck(7'h10, "R9 low half unchanged");
    doWrite(7'h50, 16'h1357, "R9 high half open");
    readCheck(7'h50, "R9 high half written");
    fullWriteEn = 1'b1;
    repeat (6) @(negedge clk);

    // R5 disable
    setLatch(1'b0);
    doWrite(7'h60, 16'h4242, "R5 after disable");
    readCheck(7'h60, "R5 disabled unchanged");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule